// File: doc/BRIEF.md
# Latch-Array Static RAM with Shared Data Bus

This block is a small static RAM that works without a clock. Each stored bit sits in a level-sensitive latch. A row decoder turns the address into one row select, and that select enables every latch of the word. While the chip is selected and the write strobe is active, the selected row is transparent and follows the shared data bus. When the strobe or the select is released, the row keeps the last value it saw.

Reads use the same pins. When the chip is selected, the output enable is active and no write is requested, the addressed word goes through a gated tri-state driver onto the bidirectional bus. At all other times the block leaves the bus undriven. A write request always wins over the output enable, so the RAM never drives against the device that supplies write data. The read path is combinational: the bus follows the address and the stored contents directly. Depth follows the address width, and the word width and the polarity of each control pin are parameters. By default all three control pins are active-low, with 3 address bits and 4-bit words.

The device that drives the block must hold the address steady for the whole write pulse. Latches that have never been written have undefined contents.

Top module: `latch_sram_bus`

## Requirements
- R1: Address value n selects row n alone, so that 0 reaches the first word and 7 the last. Each row is a distinct storage location.
- R2: With chip select low and write strobe low (active-low defaults), the addressed word takes the value on the data bus. Bus bit i is stored in column i, and bit 3 is the most significant.
- R3: During a write pulse the selected row is transparent. If the bus value changes within the pulse, the word holds the value present when the pulse ends.
- R4: After the write strobe or chip select is released, later bus activity leaves the stored word unchanged. This includes a bus value presented while the chip is selected with both strobes inactive.
- R5: A write changes only the addressed row. All other rows keep their contents.
- R6: With chip select low, output enable low and write strobe high, the block drives the addressed word onto the data bus.
- R7: With chip select high, the bus is undriven and no row is written, whatever the levels of the write strobe and output enable.
- R8: With output enable high, the block does not drive the bus.
- R9: When chip select, write strobe and output enable are all active together, the write takes effect and the block leaves the bus undriven.
- R10: The read data follows an address change during a read with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | ADDR_W | Word address, decoded to one row |
| chip_sel | input | 1 | Chip select, active-low by default |
| wr_strobe | input | 1 | Write strobe, active-low by default; level-sensitive |
| out_en | input | 1 | Output enable, active-low by default |
| data_io | inout | DATA_W | Shared bidirectional data bus |

## Verification
A wrong row select shows up the first time a different word is read back. It appears either as a value stored at the wrong location or as an overwritten neighbour, with no delay after the read begins. A latch that is not transparent for the whole pulse, or one that stays open after the pulse, only shows on a later read, because a read cannot overlap a write. A wrong driver enable shows at once at the bus as a driven value where the pull level is expected, or as a pull level where data is expected.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

    typedef struct packed {
        logic sel;    // chip selected
        logic wr;     // write window open
        logic rd;     // output drivers allowed
    } ctrl_t;

    function automatic logic pin_active(input logic pin, input bit active_low);
        return active_low ? ~pin : pin;
    endfunction

endpackage

// File: rtl/lsram_ctrl.sv
module lsram_ctrl
    import lsram_pkg::*;
#(
    parameter bit CS_LOW = 1'b1,
    parameter bit WE_LOW = 1'b1,
    parameter bit OE_LOW = 1'b1
) (
    input  logic  cs_pin,
    input  logic  we_pin,
    input  logic  oe_pin,
    output ctrl_t ctrl_d
);

    logic sel_lvl;
    logic we_lvl;
    logic oe_lvl;

    always_comb begin
        sel_lvl = pin_active(cs_pin, CS_LOW);
        we_lvl  = pin_active(we_pin, WE_LOW);
        oe_lvl  = pin_active(oe_pin, OE_LOW);

        ctrl_d     = '0;
        ctrl_d.sel = sel_lvl;
        ctrl_d.wr  = sel_lvl & we_lvl;
        // a pending write blocks the drivers to keep the bus free
        ctrl_d.rd  = sel_lvl & oe_lvl & ~we_lvl;
    end

endmodule

// File: rtl/lsram_row_dec.sv
module lsram_row_dec #(
    parameter int ADDR_W = 3,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    input  logic              wr,
    output logic [DEPTH-1:0]  row_sel,
    output logic [DEPTH-1:0]  row_wr
);

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        assign row_sel[r] = sel && (addr == ADDR_W'(r));
        assign row_wr[r]  = row_sel[r] && wr;
    end

endmodule

// File: rtl/lsram_row.sv
module lsram_row #(
    parameter int DATA_W = 4
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] word_q
);

    // level-sensitive storage: open while wr_en is high, holds after
    always_latch begin
        if (wr_en) begin
            word_q = din;
        end
    end

endmodule

// File: rtl/lsram_rd_path.sv
module lsram_rd_path #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         rd,
    output logic [DATA_W-1:0]            drive_val,
    output logic                         drive_en
);

    always_comb begin
        drive_val = words[addr];
        drive_en  = rd;
    end

endmodule

// File: rtl/latch_sram_bus.sv
module latch_sram_bus
    import lsram_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4,
    parameter bit CS_LOW = 1'b1,
    parameter bit WE_LOW = 1'b1,
    parameter bit OE_LOW = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_sel,
    input  logic              wr_strobe,
    input  logic              out_en,
    inout  wire  [DATA_W-1:0] data_io
);

    localparam int DEPTH = 1 << ADDR_W;

    ctrl_t                        ctrl_d;
    logic [DEPTH-1:0]             row_sel;
    logic [DEPTH-1:0]             row_wr;
    logic [DEPTH-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]            drive_val;
    logic                         drive_en;

    lsram_ctrl #(
        .CS_LOW (CS_LOW),
        .WE_LOW (WE_LOW),
        .OE_LOW (OE_LOW)
    ) u_ctrl (
        .cs_pin (chip_sel),
        .we_pin (wr_strobe),
        .oe_pin (out_en),
        .ctrl_d (ctrl_d)
    );

    lsram_row_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr    (addr),
        .sel     (ctrl_d.sel),
        .wr      (ctrl_d.wr),
        .row_sel (row_sel),
        .row_wr  (row_wr)
    );

    for (genvar r = 0; r < DEPTH; r++) begin : g_word
        lsram_row #(
            .DATA_W (DATA_W)
        ) u_row (
            .wr_en  (row_wr[r]),
            .din    (data_io),
            .word_q (words[r])
        );
    end

    lsram_rd_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .words     (words),
        .addr      (addr),
        .rd        (ctrl_d.rd),
        .drive_val (drive_val),
        .drive_en  (drive_en)
    );

    assign data_io = drive_en ? drive_val : {DATA_W{1'bz}};

endmodule

// File: rtl/lsram_chk.sv
module lsram_chk #(
    parameter int ADDR_W = 3,
    parameter bit CS_LOW = 1'b1,
    parameter bit WE_LOW = 1'b1,
    parameter bit OE_LOW = 1'b1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic             chip_sel,
    input logic             wr_strobe,
    input logic             out_en,
    input logic [DEPTH-1:0] row_sel,
    input logic [DEPTH-1:0] row_wr,
    input logic             drive_en
);

    logic cs_on;
    logic we_on;
    logic oe_on;
    logic known;

    always_comb begin
        cs_on = CS_LOW ? !chip_sel  : chip_sel;
        we_on = WE_LOW ? !wr_strobe : wr_strobe;
        oe_on = OE_LOW ? !out_en    : out_en;
        known = !$isunknown({chip_sel, wr_strobe, out_en});
    end

    always_comb begin
        if (known && cs_on) begin
            AST_ONE_ROW: assert ($countones(row_sel) == 1) else $error("row select not one-hot"); // R1
        end
        if (known && !cs_on) begin
            AST_IDLE_NO_ROW: assert (row_sel == '0 && !drive_en) else $error("activity while deselected"); // R7
        end
        if (known && !(cs_on && we_on)) begin
            AST_WR_GATED: assert (row_wr == '0) else $error("row write without strobe"); // R2
        end
        if (known) begin
            AST_WR_IN_SEL: assert ((row_wr & ~row_sel) == '0) else $error("write outside selected row"); // R5
        end
        if (known && we_on) begin
            AST_WR_NO_DRIVE: assert (!drive_en) else $error("driving during write"); // R9
        end
        if (known && !oe_on) begin
            AST_OE_OFF: assert (!drive_en) else $error("driving with output disabled"); // R8
        end
    end

endmodule

bind latch_sram_bus lsram_chk #(
    .ADDR_W (ADDR_W),
    .CS_LOW (CS_LOW),
    .WE_LOW (WE_LOW),
    .OE_LOW (OE_LOW)
) u_chk (
    .chip_sel  (chip_sel),
    .wr_strobe (wr_strobe),
    .out_en    (out_en),
    .row_sel   (row_sel),
    .row_wr    (row_wr),
    .drive_en  (drive_en)
);

// File: tb/latch_sram_bus_test.sv
module latch_sram_bus_test;

    localparam int AW = 3;
    localparam int DW = 4;
    localparam logic [DW-1:0] PULL = 4'hF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          tb_drv = 1'b0;
    logic [DW-1:0] tb_val = '0;
    wire  [DW-1:0] data_io;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [DW-1:0] got;

    assign data_io = tb_drv ? tb_val : {DW{1'bz}};

    for (genvar i = 0; i < DW; i++) begin : g_pull
        pullup (data_io[i]);
    end

    latch_sram_bus uut (
        .addr      (addr),
        .chip_sel  (cs_n),
        .wr_strobe (we_n),
        .out_en    (oe_n),
        .data_io   (data_io)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // {address, data}; address 6 receives 1001
    localparam logic [AW+DW-1:0] VEC [8] = '{
        {3'd0, 4'hA}, {3'd1, 4'h5}, {3'd2, 4'h3}, {3'd3, 4'hC},
        {3'd4, 4'h0}, {3'd5, 4'h7}, {3'd6, 4'h9}, {3'd7, 4'hE}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; tb_val = d; tb_drv = 1'b1;
        #2; cs_n = 1'b0; we_n = 1'b0;
        #5; we_n = 1'b1; cs_n = 1'b1;
        #2; tb_drv = 1'b0;
        #1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] v);
        tb_drv = 1'b0; addr = a;
        #1; cs_n = 1'b0; oe_n = 1'b0;
        #3; v = data_io;
        cs_n = 1'b1; oe_n = 1'b1;
        #1;
    endtask

    initial begin
        #20; rst = 1'b0;
        #3;
        // reset state: idle pins leave the bus to the pull level
        check("R7 idle bus", data_io, PULL);

        // table: fill every row, then read each back
        for (int i = 0; i < 8; i++) begin
            do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
        end
        for (int i = 0; i < 8; i++) begin
            do_read(VEC[i][AW+DW-1:DW], got);
            check("R1 R2 R6 readback", got, VEC[i][DW-1:0]);
        end

        // R3: value changes inside the pulse, last one kept
        addr = 3'd2; tb_val = 4'h6; tb_drv = 1'b1;
        #2; cs_n = 1'b0; we_n = 1'b0;
        #3; tb_val = 4'h1;
        #3; tb_val = 4'hB;
        #3; we_n = 1'b1; cs_n = 1'b1;
        #2; tb_drv = 1'b0; #1;
        do_read(3'd2, got);
        check("R3 transparent write", got, 4'hB);

        // R5: neighbours untouched
        do_read(3'd1, got);
        check("R5 row1 kept", got, 4'h5);
        do_read(3'd3, got);
        check("R5 row3 kept", got, 4'hC);

        // R4: bus activity after release, and while selected but idle
        addr = 3'd2; tb_val = 4'h4; tb_drv = 1'b1; #3;
        cs_n = 1'b0; #3; cs_n = 1'b1; #2;
        tb_drv = 1'b0; #1;
        do_read(3'd2, got);
        check("R4 hold after release", got, 4'hB);

        // R7: deselected with strobe and enable active
        addr = 3'd0; cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; #3;
        check("R7 deselected undriven", data_io, PULL);
        tb_val = 4'h1; tb_drv = 1'b1; #3;
        tb_drv = 1'b0; we_n = 1'b1; oe_n = 1'b1; #1;
        do_read(3'd0, got);
        check("R7 no write when deselected", got, 4'hA);

        // R8: selected, output disabled
        addr = 3'd0; cs_n = 1'b0; #3;
        check("R8 output disabled", data_io, PULL);
        cs_n = 1'b1; #1;

        // R10: address change during read, no clock
        addr = 3'd6; cs_n = 1'b0; oe_n = 1'b0; #2;
        check("R10 read row6", data_io, 4'h9);
        addr = 3'd1; #1;
        check("R10 follows address", data_io, 4'h5);
        cs_n = 1'b1; oe_n = 1'b1; #1;

        // R9: all three active, block must not drive (row4 holds 0)
        addr = 3'd4; #1;
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; #3;
        check("R9 no drive during write", data_io, PULL);
        we_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1; #1;
        do_read(3'd4, got);
        check("R9 write took effect", got, PULL);

        // R9 with driven data
        addr = 3'd7; tb_val = 4'h2; tb_drv = 1'b1; #1;
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; #3;
        we_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1; #2;
        tb_drv = 1'b0; #1;
        do_read(3'd7, got);
        check("R9 write wins over read", got, 4'h2);
        do_read(3'd6, got);
        check("R5 row6 kept", got, 4'h9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule